// File: doc/BRIEF.md
# Decode-Stage Branch Target Checker

This block sits in a decode stage and looks at one group of up to `W` decoded instructions per cycle. The instructions are in program order by slot. For each slot it receives a valid bit, a thread tag and a sequence number. It also receives the predicted-taken bit and the predicted target from the front end, together with a target already computed by separate address logic. Three flags classify the instruction: control, direct and unconditional. The only instructions whose target can be settled this early are those that are direct and unconditional control. For these the block compares the computed target with the prediction. A disagreement means the front end went the wrong way, and decode can correct it long before execution does.

When the block finds a disagreement, it sends a one-cycle redirect to fetch. The redirect carries the sequence number and thread of the offending instruction, the correct next PC and a taken indication. Processing of the group stops at that instruction, but the instruction itself is still forwarded. Later slots of the same thread with a larger sequence number are reported as squashed. Any other later slots are reported as held, so that upstream logic can present them again. A predicted-taken instruction that is not a control instruction is a fatal condition. The block raises an error pulse and counts it. Slots with no source operands are marked ready to issue.

All outputs are registered, so each group's results appear one clock after the group is presented. Three running counters are kept: resolved branches, target mispredictions and control mispredictions.

Top module: `dec_tgt_check`

## Requirements
- R1: A slot is checked only if it is valid and has `is_ctrl`, `is_direct` and `is_uncond` all set. `cnt_resolved` grows by the number of checked slots that were processed; a slot is processed if it is valid and no earlier slot in the group mismatched. A conditional or indirect control slot never causes a redirect, whatever its targets are.
- R2: A checked slot whose computed target differs from its predicted target causes the following outputs one cycle later: a one-cycle `redir_valid` with `redir_seq`, `redir_tid` and `redir_pc` (the computed target) of that slot, and `redir_taken` = 1. At the same edge, `cnt_mispred` increments by one.
- R3: When several checked slots of a group mismatch, only the lowest-numbered slot is reported. Slots after it are not processed and are not counted.
- R4: The mismatching slot and all valid slots before it appear in `out_valid`. Valid slots after it do not appear in `out_valid`; each is reported in exactly one of `out_squashed` or `out_held`.
- R5: A valid slot after the mismatch is squashed when it has the same thread tag and a strictly larger sequence number than the mismatching slot. Sequence numbers are assumed not to wrap within a group. Any other later slot, whether older or from another thread, is held.
- R6: Each processed slot with `pred_taken` = 1 and `is_ctrl` = 0 raises `bad_pred_err` one cycle later. Each such slot adds one to `cnt_ctrl_mispred`.
- R7: `out_ready_issue` is set for each forwarded slot whose `no_src` input was 1. It is never set for a slot that is not forwarded.
- R8: A redirect issued while `stage_stalled` is 1 is accompanied by `redir_unblock` = 1. Without a redirect, or when `stage_stalled` is 0, `redir_unblock` is 0.
- R9: After reset, all slot outputs, redirect outputs, the error pulse and all three counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_stalled | input | 1 | Decode is currently blocked or draining its skid storage |
| in_valid | input | W | Slot holds an instruction |
| in_tid | input | W*TW | Thread tag per slot |
| in_seq | input | W*SW | Sequence number per slot |
| in_pred_taken | input | W | Front end predicted taken |
| in_pred_tgt | input | W*AW | Predicted target per slot |
| in_calc_tgt | input | W*AW | Target computed at decode per slot |
| in_is_ctrl | input | W | Instruction is a control transfer |
| in_is_direct | input | W | Target is encoded in the instruction |
| in_is_uncond | input | W | Transfer is always taken |
| in_no_src | input | W | Instruction has no source operands |
| out_valid | output | W | Slot forwarded downstream |
| out_squashed | output | W | Slot killed as younger than the redirect |
| out_held | output | W | Slot not processed and must be re-presented |
| out_ready_issue | output | W | Forwarded slot may issue at once |
| redir_valid | output | 1 | One-cycle redirect to fetch |
| redir_tid | output | TW | Thread of the redirect |
| redir_seq | output | SW | Sequence number of the offending instruction |
| redir_pc | output | AW | Correct next PC |
| redir_taken | output | 1 | Corrected path is taken |
| redir_unblock | output | 1 | Fetch may also resume from a stall |
| bad_pred_err | output | 1 | Non-control instruction was predicted taken |
| cnt_resolved | output | CW | Running count of resolved direct unconditional branches |
| cnt_mispred | output | CW | Running count of target mispredictions |
| cnt_ctrl_mispred | output | CW | Running count of non-control taken predictions |

## Verification
The assertions assume that the counters do not wrap during a run and that sequence numbers rise in program order within one thread. The bench keeps to both: it sends only a few groups, so the counts stay far below the counter limit, and it uses small sequence numbers with no wrap. The only out-of-order sequence number it uses is the deliberate older-slot case. The assertions hold whatever the slot flags say, so the bench is free to present contradictory groups. These include several mismatches, or non-control slots predicted taken, in a single group.

// File: rtl/dec_tgt_check.sv
module dec_tgt_check #(
  parameter int W  = 4,
  parameter int TW = 2,
  parameter int SW = 8,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stage_stalled,
  input  logic [W-1:0]    in_valid,
  input  logic [W*TW-1:0] in_tid,
  input  logic [W*SW-1:0] in_seq,
  input  logic [W-1:0]    in_pred_taken,
  input  logic [W*AW-1:0] in_pred_tgt,
  input  logic [W*AW-1:0] in_calc_tgt,
  input  logic [W-1:0]    in_is_ctrl,
  input  logic [W-1:0]    in_is_direct,
  input  logic [W-1:0]    in_is_uncond,
  input  logic [W-1:0]    in_no_src,
  output logic [W-1:0]    out_valid,
  output logic [W-1:0]    out_squashed,
  output logic [W-1:0]    out_held,
  output logic [W-1:0]    out_ready_issue,
  output logic            redir_valid,
  output logic [TW-1:0]   redir_tid,
  output logic [SW-1:0]   redir_seq,
  output logic [AW-1:0]   redir_pc,
  output logic            redir_taken,
  output logic            redir_unblock,
  output logic            bad_pred_err,
  output logic [CW-1:0]   cnt_resolved,
  output logic [CW-1:0]   cnt_mispred,
  output logic [CW-1:0]   cnt_ctrl_mispred
);
  localparam int NW = $clog2(W + 1);

  logic [W-1:0]  chk, mis, bad, proc, young, held;
  logic          found;
  logic [TW-1:0] k_tid;
  logic [SW-1:0] k_seq;
  logic [AW-1:0] k_pc;
  logic [NW-1:0] n_res, n_bad;

  assign chk = in_valid & in_is_ctrl & in_is_direct & in_is_uncond;
  assign bad = in_valid & in_pred_taken & ~in_is_ctrl;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_cmp
      assign mis[g] = chk[g] && (in_calc_tgt[g*AW +: AW] != in_pred_tgt[g*AW +: AW]);
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    proc  = '0;
    n_res = '0;
    n_bad = '0;
    k_tid = '0;
    k_seq = '0;
    k_pc  = '0;
    for (int i = 0; i < W; i++) begin
      if (in_valid[i] && !found) begin
        proc[i] = 1'b1;
        if (chk[i]) n_res = n_res + 1'b1;
        if (bad[i]) n_bad = n_bad + 1'b1;
        if (mis[i]) begin
          found = 1'b1;
          k_tid = in_tid[i*TW +: TW];
          k_seq = in_seq[i*SW +: SW];
          k_pc  = in_calc_tgt[i*AW +: AW];
        end
      end
    end
    for (int i = 0; i < W; i++) begin
      young[i] = in_valid[i] && !proc[i] && in_tid[i*TW +: TW] == k_tid
                 && in_seq[i*SW +: SW] > k_seq;
      held[i]  = in_valid[i] && !proc[i] && !young[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid        <= '0;
      out_squashed     <= '0;
      out_held         <= '0;
      out_ready_issue  <= '0;
      redir_valid      <= 1'b0;
      redir_tid        <= '0;
      redir_seq        <= '0;
      redir_pc         <= '0;
      redir_taken      <= 1'b0;
      redir_unblock    <= 1'b0;
      bad_pred_err     <= 1'b0;
      cnt_resolved     <= '0;
      cnt_mispred      <= '0;
      cnt_ctrl_mispred <= '0;
    end else begin
      out_valid        <= proc;
      out_squashed     <= young;
      out_held         <= held;
      out_ready_issue  <= proc & in_no_src;
      redir_valid      <= found;
      redir_tid        <= k_tid;
      redir_seq        <= k_seq;
      redir_pc         <= k_pc;
      redir_taken      <= found;
      redir_unblock    <= found && stage_stalled;
      bad_pred_err     <= n_bad != '0;
      cnt_resolved     <= cnt_resolved + CW'(n_res);
      cnt_mispred      <= cnt_mispred + CW'(found);
      cnt_ctrl_mispred <= cnt_ctrl_mispred + CW'(n_bad);
    end
  end

  assert_resolved_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_resolved - $past(cnt_resolved)) <= CW'(W));
  assert_mispred_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mispred != $past(cnt_mispred)) |-> (redir_valid && redir_taken));
  assert_mispred_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mispred - $past(cnt_mispred)) <= CW'(1));
  assert_trunc_needs_redir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_held | out_squashed)) |-> redir_valid);
  assert_ctrl_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ctrl_mispred != $past(cnt_ctrl_mispred)) |-> bad_pred_err);
  assert_ready_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready_issue & ~out_valid) == '0);
  assert_unblock_redir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_unblock |-> redir_valid);

  generate
    for (g = 0; g < W; g++) begin : g_excl
      assert_slot_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid[g], out_squashed[g], out_held[g]}));
    end
  endgenerate
endmodule

// File: tb/tb_dec_tgt_check.sv
module tb_dec_tgt_check;
  localparam int W = 4, TW = 2, SW = 8, AW = 16, CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic stage_stalled;
  logic [W-1:0] in_valid, in_pred_taken, in_is_ctrl, in_is_direct, in_is_uncond, in_no_src;
  logic [W*TW-1:0] in_tid;
  logic [W*SW-1:0] in_seq;
  logic [W*AW-1:0] in_pred_tgt, in_calc_tgt;
  logic [W-1:0] out_valid, out_squashed, out_held, out_ready_issue;
  logic redir_valid, redir_taken, redir_unblock, bad_pred_err;
  logic [TW-1:0] redir_tid;
  logic [SW-1:0] redir_seq;
  logic [AW-1:0] redir_pc;
  logic [CW-1:0] cnt_resolved, cnt_mispred, cnt_ctrl_mispred;

  dec_tgt_check #(.W(W), .TW(TW), .SW(SW), .AW(AW), .CW(CW)) dut (.*);

  int checks = 0, fails = 0;
  int e_res = 0, e_mis = 0, e_ctl = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    stage_stalled = 0; in_valid = '0; in_pred_taken = '0; in_is_ctrl = '0;
    in_is_direct = '0; in_is_uncond = '0; in_no_src = '0; in_tid = '0;
    in_seq = '0; in_pred_tgt = '0; in_calc_tgt = '0;
  endtask

  task automatic slot(int i, logic [TW-1:0] t, logic [SW-1:0] s, logic ctl, logic dir,
                      logic unc, logic pt, logic [AW-1:0] ptg, logic [AW-1:0] ctg);
    in_valid[i] = 1; in_tid[i*TW +: TW] = t; in_seq[i*SW +: SW] = s;
    in_is_ctrl[i] = ctl; in_is_direct[i] = dir; in_is_uncond[i] = unc;
    in_pred_taken[i] = pt; in_pred_tgt[i*AW +: AW] = ptg; in_calc_tgt[i*AW +: AW] = ctg;
  endtask

  task automatic go();
    @(negedge clk);
    clr();
  endtask

  task automatic chk_counts(string tag);
    chk({tag, " cnt_resolved R1"}, 32'(cnt_resolved), 32'(e_res));
    chk({tag, " cnt_mispred R2"}, 32'(cnt_mispred), 32'(e_mis));
    chk({tag, " cnt_ctrl_mispred R6"}, 32'(cnt_ctrl_mispred), 32'(e_ctl));
  endtask

  task automatic t_reset();
    chk("reset out_valid R9", 32'(out_valid), 0);
    chk("reset redir_valid R9", 32'(redir_valid), 0);
    chk("reset err R9", 32'(bad_pred_err), 0);
    chk_counts("reset R9");
  endtask

  task automatic t_match();
    slot(0, 0, 1, 1, 1, 1, 1, 16'h100, 16'h100);
    slot(1, 0, 2, 0, 0, 0, 0, 0, 0);
    in_no_src = 4'b0011;
    go(); e_res += 1;
    chk("match out_valid R4", 32'(out_valid), 32'h3);
    chk("match no redirect R1", 32'(redir_valid), 0);
    chk("ready issue R7", 32'(out_ready_issue), 32'h3);
    chk_counts("match");
  endtask

  task automatic t_cond();
    slot(0, 0, 3, 1, 1, 0, 1, 16'h200, 16'h204);
    slot(1, 0, 4, 1, 0, 1, 1, 16'h300, 16'h304);
    go();
    chk("cond/indirect no redirect R1", 32'(redir_valid), 0);
    chk("cond out_valid R1", 32'(out_valid), 32'h3);
    chk_counts("cond R1");
  endtask

  task automatic t_mis_stalled();
    stage_stalled = 1;
    slot(0, 0, 10, 0, 0, 0, 0, 0, 0);
    slot(1, 0, 11, 1, 1, 1, 1, 16'h400, 16'h480);
    slot(2, 0, 12, 0, 0, 0, 0, 0, 0);
    slot(3, 1, 5, 0, 0, 0, 0, 0, 0);
    in_no_src = 4'b1111;
    go(); e_res += 1; e_mis += 1;
    chk("mis redir_valid R2", 32'(redir_valid), 1);
    chk("mis redir_seq R2", 32'(redir_seq), 11);
    chk("mis redir_tid R2", 32'(redir_tid), 0);
    chk("mis redir_pc R2", 32'(redir_pc), 32'h480);
    chk("mis redir_taken R2", 32'(redir_taken), 1);
    chk("mis out_valid R4", 32'(out_valid), 32'h3);
    chk("mis squashed R5", 32'(out_squashed), 32'h4);
    chk("mis held R5", 32'(out_held), 32'h8);
    chk("mis ready only fwd R7", 32'(out_ready_issue), 32'h3);
    chk("mis unblock R8", 32'(redir_unblock), 1);
    chk_counts("mis");
    @(negedge clk);
    chk("redirect one cycle R2", 32'(redir_valid), 0);
    chk("unblock cleared R8", 32'(redir_unblock), 0);
  endtask

  task automatic t_two_mis();
    slot(0, 2, 30, 1, 1, 1, 1, 16'h500, 16'h510);
    slot(1, 2, 31, 0, 0, 0, 1, 0, 0);
    slot(2, 2, 32, 1, 1, 1, 1, 16'h600, 16'h610);
    slot(3, 2, 33, 0, 0, 0, 0, 0, 0);
    go(); e_res += 1; e_mis += 1;
    chk("two mis seq oldest R3", 32'(redir_seq), 30);
    chk("two mis pc R3", 32'(redir_pc), 32'h510);
    chk("two mis out_valid R3", 32'(out_valid), 32'h1);
    chk("two mis squashed R5", 32'(out_squashed), 32'he);
    chk("two mis no err after trunc R6", 32'(bad_pred_err), 0);
    chk("two mis no unblock R8", 32'(redir_unblock), 0);
    chk_counts("two mis R3");
  endtask

  task automatic t_bad();
    slot(0, 1, 40, 0, 0, 0, 1, 16'h10, 0);
    slot(1, 1, 41, 0, 0, 0, 1, 16'h20, 0);
    slot(2, 1, 42, 0, 0, 0, 0, 0, 0);
    in_no_src = 4'b0010;
    go(); e_ctl += 2;
    chk("bad err R6", 32'(bad_pred_err), 1);
    chk("bad no redirect R6", 32'(redir_valid), 0);
    chk("bad ready R7", 32'(out_ready_issue), 32'h2);
    chk_counts("bad R6");
    @(negedge clk);
    chk("bad err pulse R6", 32'(bad_pred_err), 0);
  endtask

  task automatic t_older();
    slot(0, 3, 20, 1, 1, 1, 0, 16'h700, 16'h704);
    slot(1, 3, 15, 0, 0, 0, 0, 0, 0);
    slot(2, 3, 21, 0, 0, 0, 0, 0, 0);
    go(); e_res += 1; e_mis += 1;
    chk("older held R5", 32'(out_held), 32'h2);
    chk("older squashed R5", 32'(out_squashed), 32'h4);
    chk("older out_valid R4", 32'(out_valid), 32'h1);
    chk_counts("older");
  endtask

  initial begin
    fork
      begin
        clr();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_match();
        t_cond();
        t_mis_stalled();
        t_two_mis();
        t_bad();
        t_older();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule